// File: doc/BRIEF.md
# Serial Converter Output Emulator

This block stands in for the device end of a three-wire serial converter link, so that a host-side serial reader can be exercised in a loopback without a real converter. After reset it spends a fixed number of system clock cycles converting. It then captures a 16-bit word from its sample input and goes to sleep, holding that word until a host reads it out over the serial link.

While chip select is low, the data line also acts as a status flag. It is high while a conversion is running. It is low once a result is waiting and no bit has yet been clocked out. The host then gives 16 clock pulses to read the word, most significant bit first. A new conversion begins when chip select returns high, or when a 17th clock pulse arrives with chip select still low. A rising chip select part way through a read abandons the word.

Chip select and the serial clock are taken as synchronous to the system clock. The serial clock's idle level is a parameter. An edge that leaves the idle level is a leading edge, and it presents the next bit. The host samples that bit on the edge that returns to idle. When chip select is high the data line is not driven; this is shown by a low output-enable.

Top module: `ser_emu`

## Requirements
- R1: While reset is high and in the first cycle after it, `sdo_en` and `sdo` are 0, and the block is converting.
- R2: `sdo_en` equals the inverse of `cs_n` sampled at the previous clock edge, and `sdo` is 0 whenever `sdo_en` is 0.
- R3: While converting, with the data line driven, `sdo` is 1.
- R4: A conversion lasts `CONV_CYCLES` clock edges, then the block enters sleep by itself. `sample_in` is captured on the edge that ends the conversion, and later changes to it do not alter the word that is read.
- R5: In sleep, with the data line driven and no leading edge yet seen, `sdo` is 0.
- R6: In sleep with `cs_n` low, the k-th leading edge of `sck` (k = 1..16) makes `sdo` show word bit 16-k one clock later. The bits therefore come out most significant first.
- R7: A rising edge of `cs_n` during sleep starts a conversion at once, even part way through a read. The next read returns the new sample, not the rest of the old word.
- R8: A 17th leading edge of `sck` with `cs_n` low starts a conversion, and `sdo` goes to 1 one clock later.
- R9: `sck` edges while `cs_n` is high, and any `sck` or `cs_n` activity during a conversion, do not change the read position or the conversion length.
- R10: `CPOL` sets the idle level of `sck` (1 = idle high, 0 = idle low). Two instances that see mirrored clocks produce the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host, idle level set by `CPOL` |
| sample_in | input | W | Word captured when a conversion finishes |
| sdo | output | 1 | Serial data and status line (registered) |
| sdo_en | output | 1 | Data line drive enable; 0 means released |

## Verification
A wrong phase shows on the very next driven cycle, because the data line carries 1 while converting and 0 once a result is waiting. A comparison of the ports every clock therefore catches it within one cycle of chip select going low. A wrong bit position or a lost captured word appears as a wrong bit one clock after a leading edge. A timer that is off by one moves the high-to-low status change by a cycle. A missed restart shows a 0 where a 1 is expected on the cycle after the 17th pulse or after a chip select rise.

// File: rtl/ser_emu_pkg.sv
package ser_emu_pkg;
  typedef enum logic {
    PH_CONV  = 1'b0,
    PH_SLEEP = 1'b1
  } phase_t;
endpackage

// File: rtl/ser_emu_edge.sv
module ser_emu_edge #(
  parameter bit IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  output logic lead,
  output logic cs_rise
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= IDLE;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  // A leading edge leaves the idle level.
  assign lead    = (sck != sck_q) && (sck != IDLE);
  assign cs_rise = cs_n && !cs_q;
endmodule

// File: rtl/ser_emu_timer.sv
module ser_emu_timer #(
  parameter int CONV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic zero
);
  localparam int TW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD = TW'(CONV_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= LOAD;
    else if (restart)                 cnt_q <= LOAD;
    else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ser_emu_shift.sv
module ser_emu_shift #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          advance,
  input  logic          drive,
  input  logic          conv_next,
  output logic          full,
  output logic [CW-1:0] bit_cnt,
  output logic          sdo,
  output logic          sdo_en
);
  logic [W-1:0]  sh_q, nxt_sh;
  logic [CW-1:0] cnt_q, nxt_cnt;
  logic          nxt_sdo;

  always_comb begin
    nxt_sh  = sh_q;
    nxt_cnt = cnt_q;
    if (load) begin
      nxt_sh  = load_val;
      nxt_cnt = '0;
    end else if (advance) begin
      if (cnt_q != '0) nxt_sh = {sh_q[W-2:0], 1'b0};
      nxt_cnt = cnt_q + 1'b1;
    end
    nxt_sdo = drive && (conv_next || (nxt_cnt != '0 && nxt_sh[W-1]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else begin
      sh_q   <= nxt_sh;
      cnt_q  <= nxt_cnt;
      sdo    <= nxt_sdo;
      sdo_en <= drive;
    end
  end

  assign full    = (cnt_q == CW'(W));
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/ser_emu.sv
module ser_emu
  import ser_emu_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 1000,
  parameter bit CPOL        = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         sck,
  input  logic [W-1:0] sample_in,
  output logic         sdo,
  output logic         sdo_en
);
  localparam int CW = $clog2(W + 1);

  phase_t        phase_q, nxt_phase;
  logic          lead, cs_rise, tmr_zero, full;
  logic          load, adv, restart;
  logic [CW-1:0] bit_cnt;

  ser_emu_edge #(.IDLE(CPOL)) u_edge (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n),
    .lead(lead), .cs_rise(cs_rise)
  );

  ser_emu_timer #(.CONV_CYCLES(CONV_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .run(phase_q == PH_CONV),
    .restart(restart), .zero(tmr_zero)
  );

  always_comb begin
    nxt_phase = phase_q;
    load      = 1'b0;
    adv       = 1'b0;
    restart   = 1'b0;
    unique case (phase_q)
      PH_CONV: begin
        if (tmr_zero) begin
          nxt_phase = PH_SLEEP;
          load      = 1'b1;
        end
      end
      PH_SLEEP: begin
        if (cs_rise) begin
          restart   = 1'b1;
          nxt_phase = PH_CONV;
        end else if (!cs_n && lead) begin
          if (full) begin
            restart   = 1'b1;
            nxt_phase = PH_CONV;
          end else begin
            adv = 1'b1;
          end
        end
      end
      default: nxt_phase = PH_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_CONV;
    else     phase_q <= nxt_phase;
  end

  ser_emu_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_val(sample_in),
    .advance(adv), .drive(!cs_n), .conv_next(nxt_phase == PH_CONV),
    .full(full), .bit_cnt(bit_cnt), .sdo(sdo), .sdo_en(sdo_en)
  );
endmodule

// File: rtl/ser_emu_chk.sv
module ser_emu_chk #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sdo,
  input logic          sdo_en,
  input logic          in_sleep,
  input logic [CW-1:0] bits,
  input logic          lead,
  input logic          cs_rise,
  input logic          tmr_zero
);
  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!sdo_en && !sdo));
  p_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> sdo_en);
  p_busy_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && !in_sleep) |-> sdo);
  p_expire_r4: assert property (@(posedge clk) disable iff (rst)
    (!in_sleep && tmr_zero) |=> (in_sleep && bits == '0));
  p_ready_low_r5: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && in_sleep && bits == '0) |-> !sdo);
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst)
    bits <= CW'(W));
  p_cs_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && cs_rise) |=> !in_sleep);
  p_extra_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && !cs_n && lead && bits == CW'(W)) |=> (!in_sleep && sdo));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && cs_n) |=> $stable(bits));
endmodule

bind ser_emu ser_emu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sdo(sdo), .sdo_en(sdo_en),
  .in_sleep(phase_q == ser_emu_pkg::PH_SLEEP), .bits(bit_cnt),
  .lead(lead), .cs_rise(cs_rise), .tmr_zero(tmr_zero)
);

// File: tb/ser_emu_test.sv
`timescale 1ns/1ps
module ser_emu_test;
  localparam int W    = 16;
  localparam int CONV = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         act = 1'b0;          // 1 = serial clock away from idle
  logic [W-1:0] sample_in = '0;
  logic         sdo, sdo_en, sdo0, sdo_en0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ser_emu #(.W(W), .CONV_CYCLES(CONV), .CPOL(1'b1)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(~act),
    .sample_in(sample_in), .sdo(sdo), .sdo_en(sdo_en)
  );

  ser_emu #(.W(W), .CONV_CYCLES(CONV), .CPOL(1'b0)) uut0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(act),
    .sample_in(sample_in), .sdo(sdo0), .sdo_en(sdo_en0)
  );

  // Behavioural reference model
  bit           m_conv;
  int           m_cnt, m_bits;
  logic [W-1:0] m_word;
  bit           m_pact, m_pcs;
  bit           e_en, e_sdo;

  always @(posedge clk) begin
    if (rst) begin
      m_conv = 1; m_cnt = CONV - 1; m_bits = 0; m_word = '0;
      m_pact = 0; m_pcs = 1; e_en = 0; e_sdo = 0;
    end else begin
      bit lead_e, rise_e;
      lead_e = act && !m_pact;
      rise_e = cs_n && !m_pcs;
      if (m_conv) begin
        if (m_cnt == 0) begin m_conv = 0; m_word = sample_in; m_bits = 0; end
        else m_cnt--;
      end else if (rise_e) begin
        m_conv = 1; m_cnt = CONV - 1;
      end else if (!cs_n && lead_e) begin
        if (m_bits == W) begin m_conv = 1; m_cnt = CONV - 1; end
        else m_bits++;
      end
      m_pact = act; m_pcs = cs_n;
      e_en  = !cs_n;
      e_sdo = cs_n ? 0 : m_conv ? 1 : (m_bits == 0) ? 0 : m_word[W - m_bits];
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 drive enable", {15'd0, sdo_en}, {15'd0, e_en});
      if (!e_en)        chk("R2 released", {15'd0, sdo}, 16'd0);
      else if (m_conv)  chk("R3 busy flag", {15'd0, sdo}, 16'd1);
      else if (m_bits == 0) chk("R5 ready flag", {15'd0, sdo}, 16'd0);
      else chk("R6 data bit", {15'd0, sdo}, {15'd0, e_sdo});
      chk("R10 polarity match", {14'd0, sdo0, sdo_en0}, {14'd0, sdo, sdo_en});
    end
  end

  task automatic pulse();
    act = 1'b1; @(negedge clk); @(negedge clk);
    act = 1'b0; @(negedge clk); @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [W-1:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      act = 1'b1; @(negedge clk);
      w = {w[W-2:0], sdo}; @(negedge clk);
      act = 1'b0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic wait_conv();
    repeat (CONV + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic [W-1:0] v;
    repeat (4) @(negedge clk);
    chk("R1 en in reset", {15'd0, sdo_en}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {14'd0, sdo, sdo_en}, 16'd0);

    // R9: activity during conversion is ignored; R3 busy while cs low
    sample_in = 16'hA5C3;
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    chk("R3 busy after reset", {15'd0, sdo}, 16'd1);
    pulse(); cs_n = 1'b1; @(negedge clk); cs_n = 1'b0; pulse();
    cs_n = 1'b1;
    wait_conv();
    sample_in = 16'h1234;  // R4: later change must not matter

    // R5 ready low, R6 read, R4 captured word
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    chk("R5 ready low", {15'd0, sdo}, 16'd0);
    read_bits(W, w);
    chk("R4 R6 word read", w, 16'hA5C3);

    // R8: 17th pulse restarts, busy one clock later
    sample_in = 16'h8001;
    act = 1'b1; @(negedge clk);
    chk("R8 extra pulse restart", {15'd0, sdo}, 16'd1);
    @(negedge clk); act = 1'b0;
    wait_conv();

    // R7: abort mid-read, old word discarded
    read_bits(5, w);
    chk("R7 partial bits", w, 16'h0010);
    sample_in = 16'h7FFE;
    cs_n = 1'b1; @(negedge clk);
    cs_n = 1'b0; @(negedge clk);
    chk("R7 busy after abort", {15'd0, sdo}, 16'd1);
    wait_conv();
    read_bits(W, w);
    chk("R7 new sample", w, 16'h7FFE);

    // R9: clocks with cs high in sleep do not move the read position
    cs_n = 1'b1; @(negedge clk);   // restart
    sample_in = 16'h3C96;
    wait_conv();
    for (int i = 0; i < 6; i++) pulse();
    cs_n = 1'b0; @(negedge clk); @(negedge clk);
    chk("R9 still ready low", {15'd0, sdo}, 16'd0);
    read_bits(W, w);
    chk("R9 word intact", w, 16'h3C96);
    cs_n = 1'b1; @(negedge clk);

    // Several patterns, alternating restart triggers
    v = 16'hACE1;
    for (int k = 0; k < 6; k++) begin
      v = {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
      sample_in = v;
      wait_conv();
      sample_in = ~v;
      cs_n = 1'b0; @(negedge clk);
      read_bits(W, w);
      chk("R6 pattern", w, v);
      if (k % 2 == 0) begin
        pulse();
        cs_n = 1'b1; @(negedge clk);
      end else begin
        cs_n = 1'b1; @(negedge clk);
      end
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule